// File: doc/BRIEF.md
# Planar Video Line Fetch Requester

This block produces the stream of 64-byte memory read requests that brings one video line into a display output path. The line may be spread over up to four planar buffers: luma, two chroma planes and an optional overlay plane. The requests for all planes share a single request channel. A fixed repeating slot pattern, chosen by the mode and the overlay enable, sets the order in which the planes take turns. Each plane reads consecutive 64-byte blocks from its own base address until it has issued its per-line quota.

A line-start strobe captures the configuration: width, mode, overlay enable and the four base addresses. It then clears every per-line counter and starts issuing. Only one request is outstanding at any time. It stays on the port until it is acknowledged. The block counts the bytes acknowledged in the line and flags a line-level alignment problem. A deadline counter watches the time between acknowledges and raises a sticky bandwidth-error flag when a window expires. The window length depends on the mode and on whether the overlay is enabled.

Top module: `vline_fetch_req`

## Requirements
- R1: A request, once presented (`req_valid`=1), keeps the same `req_plane` and `req_addr` until `req_ack` is sampled high or a line start occurs. At most one request is outstanding. `req_ack` sampled while `req_valid` is low changes nothing.
- R2: Plane codes are 0 = luma, 1 = first chroma, 2 = second chroma, 3 = overlay. Mode codes are 0 = image, 1 = image with 2x upscaling, 2 = raw, 3 = message passing. In image mode (code 0), a line of width W issues ceil(W/64)+2 luma requests and ceil(floor(W/2)/64)+1 requests on each chroma plane. These counts hold for W = 0 as well.
- R3: When the overlay is enabled in an image mode, the overlay plane issues ceil(2W/64)+4 requests (mode 0). The slot pattern is overlay, luma, overlay, first chroma, overlay, luma, overlay, second chroma, so the first request of the line is an overlay request. When the overlay is disabled, no plane-3 request is ever issued.
- R4: Without the overlay, the slot pattern repeats luma, luma, first chroma, second chroma. A slot whose plane has used its quota is skipped, and the next slot in the pattern with work left is taken.
- R5: In upscaling mode (code 1), luma issues ceil(floor(W/2)/64)+2 requests and each chroma plane issues ceil(floor(W/4)/64)+2. An enabled overlay issues ceil(W/64)+4.
- R6: In raw and message modes (codes 2 and 3), only the luma plane is used, with ceil(W/64) requests and no extra requests. The chroma bases and the overlay enable have no effect.
- R7: The n-th request (counting from 0) of a plane within a line carries address base + 64·n for that plane.
- R8: `line_bytes` is 0 after reset and after a line start, and grows by exactly 64 for each acknowledged request.
- R9: One cycle after the cycle in which the line has no request left, `line_done` pulses high for one cycle, and `req_valid` is low while it is high.
- R10: From the line start, or from the previous acknowledge, the next acknowledge must be sampled within L clock edges. Otherwise `bw_err` is set at the L-th edge. L is 64 in image mode without overlay, 32 in image mode with overlay, 128 in upscaling mode without overlay, 64 in upscaling mode with overlay, and 64 in raw and message modes.
- R11: Until the first acknowledge of a line with the overlay enabled, the window is 64 edges in image mode and 128 edges in upscaling mode. In all other cases the first window equals the steady window of R10.
- R12: `bw_err` is 0 after reset and, once set, stays set until reset, across later acknowledges and line starts.
- R13: At a line start, `align_err` is set if any base address the line will use has a nonzero value in bits [5:0]. A base the mode does not use is ignored.
- R14: A line start while a line is in progress abandons it. The next request is the first luma (or overlay) request at that plane's base, and the byte count restarts from 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| line_start | input | 1 | One-cycle strobe that captures the configuration and starts a line |
| cfg_width | input | WIDTH_W | Line width W |
| cfg_mode | input | 2 | 0 image, 1 image with 2x upscaling, 2 raw, 3 message passing |
| cfg_ovl_en | input | 1 | Overlay plane enable (image modes only) |
| cfg_base_y | input | ADDR_W | Luma plane base address |
| cfg_base_u | input | ADDR_W | First chroma plane base address |
| cfg_base_v | input | ADDR_W | Second chroma plane base address |
| cfg_base_o | input | ADDR_W | Overlay plane base address |
| req_valid | output | 1 | A request is outstanding |
| req_plane | output | 2 | Plane code of the outstanding request |
| req_addr | output | ADDR_W | Address of the 64-byte block requested |
| req_ack | input | 1 | Acknowledge of the outstanding request |
| line_bytes | output | WIDTH_W+4 | Bytes acknowledged in the current line |
| line_done | output | 1 | One-cycle pulse when the line has no work left |
| align_err | output | 1 | A used plane base is not 64-byte aligned |
| bw_err | output | 1 | Sticky flag: an acknowledge deadline expired |

## Verification
The checker assumes that the configuration inputs stay unchanged while a line is in progress. The properties that tie request planes to the mode and overlay inputs read the live ports, not a captured copy. The bench changes configuration only while the block is idle or just after a reset, and it restarts a line mid-flight only with unchanged settings. The checker also assumes that `req_ack` is meaningful only while `req_valid` is high. The bench drives it during idle cycles only in the one scenario that proves such acknowledges are ignored, and there it watches the byte count at the ports.

// File: rtl/vfr_pkg.sv
package vfr_pkg;

    localparam int REQ_BYTES  = 64;
    localparam int REQ_SHIFT  = $clog2(REQ_BYTES);
    localparam int NUM_PLANES = 4;
    localparam int NUM_SLOTS  = 8;
    localparam int SLOT_W     = $clog2(NUM_SLOTS);

    typedef enum logic [1:0] {
        PL_LUMA = 2'd0,
        PL_CB   = 2'd1,
        PL_CR   = 2'd2,
        PL_OVL  = 2'd3
    } plane_e;

    typedef enum logic [1:0] {
        MD_IMAGE   = 2'd0,
        MD_UPSCALE = 2'd1,
        MD_RAW     = 2'd2,
        MD_MSG     = 2'd3
    } mode_e;

    typedef enum logic {
        PH_IDLE  = 1'b0,
        PH_FETCH = 1'b1
    } phase_e;

    typedef struct packed {
        logic              found;
        plane_e            plane;
        logic [SLOT_W-1:0] slot;
    } pick_t;

    function automatic logic is_image(input mode_e m);
        return (m == MD_IMAGE) || (m == MD_UPSCALE);
    endfunction

    // number of 64-byte blocks covering n bytes
    function automatic logic [31:0] blocks_of(input logic [31:0] n);
        return (n + 32'(REQ_BYTES - 1)) >> REQ_SHIFT;
    endfunction

    // plane owning a given slot of the repeating interleave pattern
    function automatic plane_e slot_plane(input mode_e m, input logic ovl,
                                          input logic [SLOT_W-1:0] s);
        plane_e p;
        if (!is_image(m)) begin
            p = PL_LUMA;
        end else if (ovl) begin
            if (!s[0]) begin
                p = PL_OVL;
            end else begin
                case (s[2:1])
                    2'd1:    p = PL_CB;
                    2'd3:    p = PL_CR;
                    default: p = PL_LUMA;
                endcase
            end
        end else begin
            case (s[1:0])
                2'd2:    p = PL_CB;
                2'd3:    p = PL_CR;
                default: p = PL_LUMA;
            endcase
        end
        return p;
    endfunction

endpackage

// File: rtl/vfr_line_plan.sv
module vfr_line_plan
    import vfr_pkg::*;
#(
    parameter int WIDTH_W = 12,
    parameter int CNT_W   = 9
) (
    input  logic [WIDTH_W-1:0]                  width,
    input  mode_e                               mode,
    input  logic                                ovl,
    output logic [NUM_PLANES-1:0][CNT_W-1:0]    quota
);

    logic [31:0] w_full;
    logic [31:0] luma_px, chroma_px, ovl_px;
    logic [31:0] luma_n, chroma_n, ovl_n;
    logic [31:0] luma_pad, chroma_pad;
    logic        up;

    always_comb begin
        w_full    = 32'(width);
        up        = (mode == MD_UPSCALE);
        luma_px   = up ? (w_full >> 1) : w_full;
        chroma_px = up ? (w_full >> 2) : (w_full >> 1);
        ovl_px    = up ? w_full : (w_full << 1);

        luma_pad   = is_image(mode) ? 32'd2 : 32'd0;
        chroma_pad = up ? 32'd2 : 32'd1;

        luma_n   = blocks_of(luma_px) + luma_pad;
        chroma_n = is_image(mode) ? (blocks_of(chroma_px) + chroma_pad) : 32'd0;
        ovl_n    = (is_image(mode) && ovl) ? (blocks_of(ovl_px) + 32'd4) : 32'd0;

        quota[PL_LUMA] = CNT_W'(luma_n);
        quota[PL_CB]   = CNT_W'(chroma_n);
        quota[PL_CR]   = CNT_W'(chroma_n);
        quota[PL_OVL]  = CNT_W'(ovl_n);
    end

endmodule

// File: rtl/vfr_slot_pick.sv
module vfr_slot_pick
    import vfr_pkg::*;
(
    input  logic [SLOT_W-1:0]     slot,
    input  mode_e                 mode,
    input  logic                  ovl,
    input  logic [NUM_PLANES-1:0] has_work,
    output pick_t                 pick
);

    logic [SLOT_W-1:0] cand;
    plane_e            cand_pl;

    // scan the pattern from the current slot; the nearest slot with work wins
    always_comb begin
        pick    = '{found: 1'b0, plane: PL_LUMA, slot: '0};
        cand    = '0;
        cand_pl = PL_LUMA;
        for (int k = NUM_SLOTS - 1; k >= 0; k--) begin
            cand    = slot + SLOT_W'(k);
            cand_pl = slot_plane(mode, ovl, cand);
            if (has_work[cand_pl]) begin
                pick = '{found: 1'b1, plane: cand_pl, slot: cand};
            end
        end
    end

endmodule

// File: rtl/vfr_deadline.sv
module vfr_deadline
    import vfr_pkg::*;
#(
    parameter int BASE_WIN = 64
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  restart,
    input  mode_e mode,
    input  logic  ovl,
    input  logic  pending,
    input  logic  ack,
    output logic  bw_err
);

    localparam int LIM_W = $clog2(2 * BASE_WIN + 1);

    logic [LIM_W-1:0] lim_first, lim_steady, lim;
    logic [LIM_W-1:0] elapsed;
    logic             first_q;

    always_comb begin
        case (mode)
            MD_IMAGE: begin
                lim_steady = ovl ? LIM_W'(BASE_WIN / 2) : LIM_W'(BASE_WIN);
                lim_first  = ovl ? LIM_W'(BASE_WIN) : lim_steady;
            end
            MD_UPSCALE: begin
                lim_steady = ovl ? LIM_W'(BASE_WIN) : LIM_W'(2 * BASE_WIN);
                lim_first  = ovl ? LIM_W'(2 * BASE_WIN) : lim_steady;
            end
            default: begin
                lim_steady = LIM_W'(BASE_WIN);
                lim_first  = LIM_W'(BASE_WIN);
            end
        endcase
        lim = first_q ? lim_first : lim_steady;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            elapsed <= '0;
            first_q <= 1'b1;
            bw_err  <= 1'b0;
        end else if (restart) begin
            elapsed <= '0;
            first_q <= 1'b1;
        end else if (pending) begin
            if (ack) begin
                elapsed <= '0;
                first_q <= 1'b0;
            end else if (elapsed == lim - LIM_W'(1)) begin
                bw_err <= 1'b1;
            end else begin
                elapsed <= elapsed + LIM_W'(1);
            end
        end
    end

endmodule

// File: rtl/vline_fetch_req.sv
module vline_fetch_req
    import vfr_pkg::*;
#(
    parameter  int WIDTH_W  = 12,
    parameter  int ADDR_W   = 32,
    parameter  int BASE_WIN = 64,
    localparam int BYTE_W   = WIDTH_W + 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               line_start,
    input  logic [WIDTH_W-1:0] cfg_width,
    input  logic [1:0]         cfg_mode,
    input  logic               cfg_ovl_en,
    input  logic [ADDR_W-1:0]  cfg_base_y,
    input  logic [ADDR_W-1:0]  cfg_base_u,
    input  logic [ADDR_W-1:0]  cfg_base_v,
    input  logic [ADDR_W-1:0]  cfg_base_o,
    output logic               req_valid,
    output logic [1:0]         req_plane,
    output logic [ADDR_W-1:0]  req_addr,
    input  logic               req_ack,
    output logic [BYTE_W-1:0]  line_bytes,
    output logic               line_done,
    output logic               align_err,
    output logic               bw_err
);

    localparam int CNT_W = WIDTH_W - 3;

    mode_e                               mode_in, mode_q;
    logic                                ovl_in, ovl_q;
    logic [NUM_PLANES-1:0][ADDR_W-1:0]   base_in, base_q;
    logic [NUM_PLANES-1:0][CNT_W-1:0]    quota, rem_q, idx_q;
    logic [NUM_PLANES-1:0]               has_work, misaligned, used;
    logic [SLOT_W-1:0]                   slot_q;
    phase_e                              phase;
    pick_t                               pick;
    logic                                accept;

    assign mode_in = mode_e'(cfg_mode);
    assign ovl_in  = cfg_ovl_en && is_image(mode_in);

    assign base_in[PL_LUMA] = cfg_base_y;
    assign base_in[PL_CB]   = cfg_base_u;
    assign base_in[PL_CR]   = cfg_base_v;
    assign base_in[PL_OVL]  = cfg_base_o;

    assign used[PL_LUMA] = 1'b1;
    assign used[PL_CB]   = is_image(mode_in);
    assign used[PL_CR]   = is_image(mode_in);
    assign used[PL_OVL]  = ovl_in;

    for (genvar p = 0; p < NUM_PLANES; p++) begin : g_plane
        assign has_work[p]   = |rem_q[p];
        assign misaligned[p] = used[p] && (|base_in[p][REQ_SHIFT-1:0]);
    end

    vfr_line_plan #(
        .WIDTH_W (WIDTH_W),
        .CNT_W   (CNT_W)
    ) u_plan (
        .width (cfg_width),
        .mode  (mode_in),
        .ovl   (ovl_in),
        .quota (quota)
    );

    vfr_slot_pick u_pick (
        .slot     (slot_q),
        .mode     (mode_q),
        .ovl      (ovl_q),
        .has_work (has_work),
        .pick     (pick)
    );

    assign req_valid = (phase == PH_FETCH) && pick.found;
    assign req_plane = pick.plane;
    assign req_addr  = base_q[pick.plane]
                     + (ADDR_W'(idx_q[pick.plane]) << REQ_SHIFT);
    assign accept    = req_valid && req_ack;

    vfr_deadline #(
        .BASE_WIN (BASE_WIN)
    ) u_deadline (
        .clk     (clk),
        .rst     (rst),
        .restart (line_start),
        .mode    (mode_q),
        .ovl     (ovl_q),
        .pending (req_valid),
        .ack     (req_ack),
        .bw_err  (bw_err)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            phase      <= PH_IDLE;
            mode_q     <= MD_IMAGE;
            ovl_q      <= 1'b0;
            base_q     <= '0;
            rem_q      <= '0;
            idx_q      <= '0;
            slot_q     <= '0;
            line_bytes <= '0;
            line_done  <= 1'b0;
            align_err  <= 1'b0;
        end else if (line_start) begin
            phase      <= PH_FETCH;
            mode_q     <= mode_in;
            ovl_q      <= ovl_in;
            base_q     <= base_in;
            rem_q      <= quota;
            idx_q      <= '0;
            slot_q     <= '0;
            line_bytes <= '0;
            line_done  <= 1'b0;
            align_err  <= |misaligned;
        end else begin
            line_done <= 1'b0;
            if (phase == PH_FETCH) begin
                if (!pick.found) begin
                    phase     <= PH_IDLE;
                    line_done <= 1'b1;
                end else if (accept) begin
                    rem_q[pick.plane] <= rem_q[pick.plane] - CNT_W'(1);
                    idx_q[pick.plane] <= idx_q[pick.plane] + CNT_W'(1);
                    slot_q            <= pick.slot + SLOT_W'(1);
                    line_bytes        <= line_bytes + BYTE_W'(REQ_BYTES);
                end
            end
        end
    end

endmodule

// File: rtl/vfr_checker.sv
module vfr_checker #(
    parameter int ADDR_W = 32,
    parameter int BYTE_W = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              line_start,
    input logic [1:0]        cfg_mode,
    input logic              cfg_ovl_en,
    input logic              req_valid,
    input logic [1:0]        req_plane,
    input logic [ADDR_W-1:0] req_addr,
    input logic              req_ack,
    input logic [BYTE_W-1:0] line_bytes,
    input logic              line_done,
    input logic              align_err,
    input logic              bw_err
);

    assert_hold_until_ack_R1: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_ack && !line_start)
        |=> (req_valid && $stable(req_plane) && $stable(req_addr)));

    assert_no_overlay_when_off_R3: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !cfg_ovl_en) |-> (req_plane != 2'd3));

    assert_raw_luma_only_R6: assert property (@(posedge clk) disable iff (rst)
        (req_valid && (cfg_mode >= 2'd2)) |-> (req_plane == 2'd0));

    assert_block_aligned_R7: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !align_err) |-> (req_addr[5:0] == 6'd0));

    assert_bytes_step_R8: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ack && !line_start)
        |=> (line_bytes == $past(line_bytes) + BYTE_W'(64)));

    assert_bytes_hold_R8: assert property (@(posedge clk) disable iff (rst)
        (!(req_valid && req_ack) && !line_start) |=> $stable(line_bytes));

    assert_done_idle_R9: assert property (@(posedge clk) disable iff (rst)
        line_done |-> !req_valid);

    assert_err_sticky_R12: assert property (@(posedge clk) disable iff (rst)
        bw_err |=> bw_err);

    assert_start_clears_R14: assert property (@(posedge clk) disable iff (rst)
        line_start |=> (line_bytes == '0 && !line_done));

endmodule

bind vline_fetch_req vfr_checker #(
    .ADDR_W (ADDR_W),
    .BYTE_W (BYTE_W)
) u_vfr_checker (.*);

// File: tb/vline_fetch_req_bench.sv
`timescale 1ns/1ps
module vline_fetch_req_bench;

    localparam int WIDTH_W = 12;
    localparam int ADDR_W  = 32;
    localparam int BYTE_W  = WIDTH_W + 4;

    localparam logic [ADDR_W-1:0] BY = 32'h0001_0000;
    localparam logic [ADDR_W-1:0] BU = 32'h0002_0000;
    localparam logic [ADDR_W-1:0] BV = 32'h0003_0000;
    localparam logic [ADDR_W-1:0] BO = 32'h0004_0000;

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic               line_start = 1'b0;
    logic [WIDTH_W-1:0] cfg_width = '0;
    logic [1:0]         cfg_mode = 2'd0;
    logic               cfg_ovl_en = 1'b0;
    logic [ADDR_W-1:0]  cfg_base_y = BY;
    logic [ADDR_W-1:0]  cfg_base_u = BU;
    logic [ADDR_W-1:0]  cfg_base_v = BV;
    logic [ADDR_W-1:0]  cfg_base_o = BO;
    logic               req_valid;
    logic [1:0]         req_plane;
    logic [ADDR_W-1:0]  req_addr;
    logic               req_ack = 1'b0;
    logic [BYTE_W-1:0]  line_bytes;
    logic               line_done;
    logic               align_err;
    logic               bw_err;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    vline_fetch_req #(
        .WIDTH_W (WIDTH_W),
        .ADDR_W  (ADDR_W)
    ) u_vline_fetch_req (.*);

    task automatic check(input bit ok, input string tag,
                         input longint actual, input longint expected);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, actual, expected);
        end
    endtask

    function automatic int blk(input int n);
        return (n + 63) / 64;
    endfunction

    function automatic logic [ADDR_W-1:0] base_of(input int p);
        case (p)
            0:       return BY;
            1:       return BU;
            2:       return BV;
            default: return BO;
        endcase
    endfunction

    task automatic do_reset();
        req_ack    = 1'b0;
        line_start = 1'b0;
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic set_cfg(input int w, input int mode, input bit ovl);
        cfg_width  = WIDTH_W'(w);
        cfg_mode   = 2'(mode);
        cfg_ovl_en = ovl;
        cfg_base_y = BY;
        cfg_base_u = BU;
        cfg_base_v = BV;
        cfg_base_o = BO;
    endtask

    // ends on the falling edge just after the edge that sampled the strobe
    task automatic pulse_start();
        @(negedge clk);
        line_start = 1'b1;
        @(negedge clk);
        line_start = 1'b0;
    endtask

    // ack sampled k rising edges after the previous reference edge
    task automatic ack_after(input int k);
        repeat (k - 1) @(posedge clk);
        @(negedge clk);
        req_ack = 1'b1;
        @(posedge clk);
        @(negedge clk);
        req_ack = 1'b0;
    endtask

    task automatic serve_line(input int ey, input int eu, input int ev, input int eo,
                              input int o0, input int o1, input int o2, input int o3,
                              input bit chk_order, input string tag);
        int seen[4];
        int order[4];
        int n;
        bit done;
        seen  = '{0, 0, 0, 0};
        order = '{o0, o1, o2, o3};
        n     = 0;
        done  = 1'b0;
        pulse_start();
        for (int g = 0; g < 4000 && !done; g++) begin
            @(negedge clk);
            req_ack = 1'b0;
            if (line_done) begin
                done = 1'b1;
                check(!req_valid, {tag, " R9 valid low with done"}, req_valid, 0);
            end else if (req_valid) begin
                int p;
                p = int'(req_plane);
                check(req_addr == base_of(p) + ADDR_W'(64 * seen[p]),
                      {tag, " R7 address"}, req_addr, base_of(p) + ADDR_W'(64 * seen[p]));
                if (chk_order && n < 4)
                    check(p == order[n], {tag, " R4 slot order"}, p, order[n]);
                seen[p]++;
                n++;
                req_ack = 1'b1;
            end
        end
        req_ack = 1'b0;
        check(done, {tag, " R9 line_done seen"}, done, 1);
        check(seen[0] == ey, {tag, " luma count"}, seen[0], ey);
        check(seen[1] == eu, {tag, " chroma1 count"}, seen[1], eu);
        check(seen[2] == ev, {tag, " chroma2 count"}, seen[2], ev);
        check(seen[3] == eo, {tag, " overlay count"}, seen[3], eo);
        check(line_bytes == BYTE_W'(64 * (ey + eu + ev + eo)), {tag, " R8 byte total"},
              line_bytes, 64 * (ey + eu + ev + eo));
        @(negedge clk);
        check(!line_done, {tag, " R9 done is one cycle"}, line_done, 0);
    endtask

    task automatic t_reset_state();
        do_reset();
        check(!req_valid, "R9 reset valid", req_valid, 0);
        check(line_bytes == 0, "R8 reset bytes", line_bytes, 0);
        check(!bw_err, "R12 reset bw_err", bw_err, 0);
        check(!align_err, "R13 reset align_err", align_err, 0);
        check(!line_done, "R9 reset done", line_done, 0);
    endtask

    task automatic t_stray_ack();
        do_reset();
        @(negedge clk);
        req_ack = 1'b1;
        repeat (3) @(negedge clk);
        req_ack = 1'b0;
        check(line_bytes == 0, "R1 idle ack ignored", line_bytes, 0);
        check(!req_valid, "R1 nothing outstanding", req_valid, 0);
    endtask

    task automatic t_image_plain();
        do_reset();
        set_cfg(256, 0, 1'b0);
        serve_line(blk(256) + 2, blk(128) + 1, blk(128) + 1, 0, 0, 0, 1, 2, 1'b1, "R2 image w256");
        set_cfg(0, 0, 1'b0);
        serve_line(2, 1, 1, 0, 0, 0, 1, 2, 1'b1, "R2 image w0");
        set_cfg(64, 0, 1'b0);
        serve_line(3, 2, 2, 0, 0, 0, 1, 2, 1'b1, "R4 skip exhausted");
    endtask

    task automatic t_image_ovl();
        do_reset();
        set_cfg(64, 0, 1'b1);
        serve_line(3, 2, 2, blk(128) + 4, 3, 0, 3, 1, 1'b1, "R3 overlay w64");
    endtask

    task automatic t_upscale();
        do_reset();
        set_cfg(256, 1, 1'b0);
        serve_line(blk(128) + 2, blk(64) + 2, blk(64) + 2, 0, 0, 0, 1, 2, 1'b1, "R5 upscale w256");
        set_cfg(256, 1, 1'b1);
        serve_line(blk(128) + 2, blk(64) + 2, blk(64) + 2, blk(256) + 4,
                   3, 0, 3, 1, 1'b1, "R5 upscale overlay");
    endtask

    task automatic t_raw();
        do_reset();
        set_cfg(200, 2, 1'b1);
        serve_line(blk(200), 0, 0, 0, 0, 0, 0, 0, 1'b1, "R6 raw w200");
        set_cfg(130, 3, 1'b0);
        serve_line(blk(130), 0, 0, 0, 0, 0, 0, 0, 1'b0, "R6 message w130");
        set_cfg(0, 2, 1'b0);
        serve_line(0, 0, 0, 0, 0, 0, 0, 0, 1'b0, "R6 raw empty line");
    endtask

    task automatic t_deadline_plain();
        do_reset();
        set_cfg(1024, 0, 1'b0);
        pulse_start();
        ack_after(64);
        check(!bw_err, "R10 first ack at 64", bw_err, 0);
        ack_after(64);
        check(!bw_err, "R10 ack at 64", bw_err, 0);
        ack_after(65);
        check(bw_err, "R10 ack at 65 misses", bw_err, 1);
        ack_after(2);
        ack_after(2);
        check(bw_err, "R12 stays set after acks", bw_err, 1);
        pulse_start();
        check(bw_err, "R12 stays set after line start", bw_err, 1);
        do_reset();
        check(!bw_err, "R12 cleared by reset", bw_err, 0);
    endtask

    task automatic t_deadline_ovl();
        do_reset();
        set_cfg(1024, 0, 1'b1);
        pulse_start();
        ack_after(64);
        check(!bw_err, "R11 overlay first window 64", bw_err, 0);
        ack_after(32);
        check(!bw_err, "R10 overlay ack at 32", bw_err, 0);
        ack_after(33);
        check(bw_err, "R10 overlay ack at 33 misses", bw_err, 1);
        do_reset();
        set_cfg(1024, 0, 1'b1);
        pulse_start();
        ack_after(65);
        check(bw_err, "R11 overlay first ack at 65 misses", bw_err, 1);
    endtask

    task automatic t_deadline_up();
        do_reset();
        set_cfg(2048, 1, 1'b0);
        pulse_start();
        ack_after(128);
        check(!bw_err, "R11 upscale ack at 128", bw_err, 0);
        ack_after(129);
        check(bw_err, "R11 upscale ack at 129 misses", bw_err, 1);
        do_reset();
        set_cfg(2048, 1, 1'b1);
        pulse_start();
        ack_after(128);
        check(!bw_err, "R11 upscale overlay first 128", bw_err, 0);
        ack_after(65);
        check(bw_err, "R11 upscale overlay steady 65 misses", bw_err, 1);
    endtask

    task automatic t_align();
        do_reset();
        set_cfg(256, 0, 1'b0);
        cfg_base_u = BU + 32'h20;
        pulse_start();
        check(align_err, "R13 chroma base unaligned", align_err, 1);
        do_reset();
        set_cfg(256, 2, 1'b0);
        cfg_base_u = BU + 32'h20;
        cfg_base_o = BO + 32'h04;
        pulse_start();
        check(!align_err, "R13 unused bases ignored", align_err, 0);
        do_reset();
        set_cfg(256, 0, 1'b1);
        cfg_base_o = BO + 32'h08;
        pulse_start();
        check(align_err, "R13 overlay base unaligned", align_err, 1);
        do_reset();
    endtask

    task automatic t_restart();
        do_reset();
        set_cfg(256, 0, 1'b0);
        pulse_start();
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            req_ack = 1'b1;
        end
        @(negedge clk);
        req_ack = 1'b0;
        check(line_bytes == 192, "R8 partial byte count", line_bytes, 192);
        check(req_plane == 2'd2 && req_addr == BV, "R4 fourth request chroma2",
              req_addr, BV);
        pulse_start();
        check(line_bytes == 0, "R14 restart clears bytes", line_bytes, 0);
        check(req_valid && req_plane == 2'd0 && req_addr == BY,
              "R14 restart first luma block", req_addr, BY);
        @(negedge clk);
        check(req_valid && req_addr == BY, "R1 held without ack", req_addr, BY);
        do_reset();
    endtask

    initial begin
        #(150000 * 20);
        if (!finished) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        t_reset_state();
        t_stray_ack();
        t_image_plain();
        t_image_ovl();
        t_upscale();
        t_raw();
        t_deadline_plain();
        t_deadline_ovl();
        t_deadline_up();
        t_align();
        t_restart();
        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

endmodule